// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block keeps an 8-bit interrupt status word and an 8-bit enable mask for a network queue engine. It drives one level-sensitive interrupt line that is high whenever any status bit is set and also enabled in the mask. Some status bits are latched from event pulses: a buffer allocation succeeded, or a frame was received. Other bits are re-asserted every cycle from live queue flags: the transmit queue is empty, or the transmit-done queue holds entries.

A host updates the block with byte writes through one select bit. When the select bit is 0, the write acknowledges status bits: each one-bit clears the matching status bit, but only for bits in a fixed clearable set. When the select bit is 1, the write loads the mask. Acknowledging the transmit-done bit also sends a pop request to the transmit-done queue, in the same cycle as the write. A receive-queue pop reloads the receive bit from the queue's remaining-entries flag. Both the status word and the mask are driven out as plain outputs, so the host can read them.

Top module: `irq_stat_ctrl`

Status bit positions: bit 0 receive, bit 1 transmit-done, bit 2 transmit-empty, bit 3 allocation. Bits 4 to 7 are reserved event bits that no input sets.

## Requirements
- R1: Synchronous reset sets the status to 0x04 and the mask to 0x00, so the interrupt line is low.
- R2: Whenever mask AND status is non-zero, the interrupt line is high; otherwise it is low. A mask or status change shows on the line in the cycle after the write or event.
- R3: A write with `wr_sel_mask`=0 clears each status bit whose data bit is 1, for bits 7, 6, 4, 2 and 1 only (clearable set 0xD6). Bits 0, 3 and 5 are left unchanged by such a write.
- R4: `txdone_pop` is high in the same cycle as a write with `wr_sel_mask`=0 and data bit 1 set, if and only if `txdone_nonempty` is high in that cycle.
- R5: When `txq_empty` is high, status bit 2 is set at the next clock edge. This holds even if the same cycle carries an acknowledge of bit 2.
- R6: When `txdone_nonempty` is high, status bit 1 is set at the next clock edge. The exception is a cycle that acknowledges bit 1: then bit 1 clears, and it follows the flag again from the next cycle.
- R7: An `alloc_evt` pulse sets status bit 3.
- R8: An `rx_pop` pulse loads status bit 0 from `rxq_nonempty` (1 when entries remain). An `rx_evt` pulse sets bit 0 and wins over a same-cycle pop that would clear it.
- R9: A write with `wr_sel_mask`=1 loads the mask from the data byte and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_sel_mask | input | 1 | 0: acknowledge status, 1: load mask |
| wr_data | input | 8 | Write data byte |
| txq_empty | input | 1 | Transmit queue holds no entries |
| txdone_nonempty | input | 1 | Transmit-done queue holds entries |
| rxq_nonempty | input | 1 | Receive queue holds entries (after any pop this cycle) |
| alloc_evt | input | 1 | Allocation-complete pulse |
| rx_evt | input | 1 | Frame-received pulse |
| rx_pop | input | 1 | Receive queue pop pulse |
| irq | output | 1 | Level interrupt line |
| txdone_pop | output | 1 | Pop request to the transmit-done queue |
| status | output | 8 | Current status word |
| mask | output | 8 | Current enable mask |

## Verification
The hardest situation to reach is a transmit-done acknowledge while the done queue still holds entries after the pop. In that case bit 1 must drop for one cycle and then come back from the live flag. The stimulus holds `txdone_nonempty` high across the acknowledge and the following cycle, and checks the pop pulse, the clear and the re-assertion in turn. It also drives a same-cycle receive event and receive pop against an empty queue, to show that the set wins.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int STAT_W = 8;

    localparam int BIT_RCV   = 0;
    localparam int BIT_TXD   = 1;
    localparam int BIT_TXE   = 2;
    localparam int BIT_ALLOC = 3;

    localparam logic [STAT_W-1:0] CLEARABLE_DEF = 8'hD6;
    localparam logic [STAT_W-1:0] RESET_DEF     = 8'h04;

    typedef struct packed {
        logic              en;
        logic              sel_mask;
        logic [STAT_W-1:0] data;
    } host_wr_t;

    typedef struct packed {
        logic txq_empty;
        logic txdone_ne;
        logic rxq_ne;
    } q_flags_t;

    typedef struct packed {
        logic alloc;
        logic rx;
        logic rx_pop;
    } evt_t;

    function automatic logic [STAT_W-1:0] ack_bits(input host_wr_t w,
                                                   input logic [STAT_W-1:0] clr_ok);
        return (w.en && !w.sel_mask) ? (w.data & clr_ok) : '0;
    endfunction

endpackage

// File: rtl/irq_stat_sources.sv
module irq_stat_sources
    import irq_stat_pkg::*;
#(
    parameter int                WIDTH     = STAT_W,
    parameter logic [WIDTH-1:0]  CLEARABLE = CLEARABLE_DEF
) (
    input  host_wr_t         host,
    input  q_flags_t         flags,
    input  evt_t             evt,
    output logic [WIDTH-1:0] set_vec,
    output logic [WIDTH-1:0] clr_vec,
    output logic             pop_req
);
    logic [WIDTH-1:0] ack;
    logic             ack_txd;

    always_comb begin
        ack     = ack_bits(host, CLEARABLE);
        ack_txd = host.en && !host.sel_mask && host.data[BIT_TXD];
        pop_req = ack_txd && flags.txdone_ne;
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_src
        if (b == BIT_RCV) begin : g_rcv
            assign set_vec[b] = evt.rx || (evt.rx_pop && flags.rxq_ne);
            assign clr_vec[b] = (evt.rx_pop && !flags.rxq_ne) || ack[b];
        end else if (b == BIT_TXD) begin : g_txd
            assign set_vec[b] = flags.txdone_ne && !ack_txd;
            assign clr_vec[b] = ack[b];
        end else if (b == BIT_TXE) begin : g_txe
            assign set_vec[b] = flags.txq_empty;
            assign clr_vec[b] = ack[b];
        end else if (b == BIT_ALLOC) begin : g_alloc
            assign set_vec[b] = evt.alloc;
            assign clr_vec[b] = ack[b];
        end else begin : g_plain
            assign set_vec[b] = 1'b0;
            assign clr_vec[b] = ack[b];
        end
    end
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] RESET = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] q
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q[b] <= RESET[b];
            end else if (set_vec[b]) begin
                q[b] <= 1'b1;
            end else if (clr_vec[b]) begin
                q[b] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_stat_pkg::*;
#(
    parameter int WIDTH = STAT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  host_wr_t         host,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (host.en && host.sel_mask) begin
            q <= host.data;
        end
    end
endmodule

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
    import irq_stat_pkg::*;
#(
    parameter int                WIDTH     = STAT_W,
    parameter logic [WIDTH-1:0]  CLEARABLE = CLEARABLE_DEF,
    parameter logic [WIDTH-1:0]  RESET_VAL = RESET_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel_mask,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             txq_empty,
    input  logic             txdone_nonempty,
    input  logic             rxq_nonempty,
    input  logic             alloc_evt,
    input  logic             rx_evt,
    input  logic             rx_pop,
    output logic             irq,
    output logic             txdone_pop,
    output logic [WIDTH-1:0] status,
    output logic [WIDTH-1:0] mask
);
    host_wr_t         host;
    q_flags_t         flags;
    evt_t             evt;
    logic [WIDTH-1:0] set_vec;
    logic [WIDTH-1:0] clr_vec;

    assign host  = '{en: wr_en, sel_mask: wr_sel_mask, data: wr_data};
    assign flags = '{txq_empty: txq_empty, txdone_ne: txdone_nonempty,
                     rxq_ne: rxq_nonempty};
    assign evt   = '{alloc: alloc_evt, rx: rx_evt, rx_pop: rx_pop};

    irq_stat_sources #(.WIDTH(WIDTH), .CLEARABLE(CLEARABLE)) u_src (
        .host    (host),
        .flags   (flags),
        .evt     (evt),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pop_req (txdone_pop)
    );

    irq_stat_reg #(.WIDTH(WIDTH), .RESET(RESET_VAL)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .q       (status)
    );

    irq_mask_reg #(.WIDTH(WIDTH)) u_mask (
        .clk  (clk),
        .rst  (rst),
        .host (host),
        .q    (mask)
    );

    assign irq = |(status & mask);
endmodule

// File: rtl/irq_stat_ctrl_checker.sv
module irq_stat_ctrl_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       wr_sel_mask,
    input logic [7:0] wr_data,
    input logic       txq_empty,
    input logic       txdone_nonempty,
    input logic       alloc_evt,
    input logic       rx_evt,
    input logic       rx_pop,
    input logic       irq,
    input logic       txdone_pop,
    input logic [7:0] status,
    input logic [7:0] mask
);
    p_mask_zero_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (mask == 8'h00) |-> !irq);

    p_protected_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel_mask && !rx_pop) |=>
        ((($past(status) & 8'h29) & ~status) == 8'h00));

    p_pop_cause_r4: assert property (@(posedge clk) disable iff (rst)
        txdone_pop |-> (wr_en && !wr_sel_mask && wr_data[1] && txdone_nonempty));

    p_txe_live_r5: assert property (@(posedge clk) disable iff (rst)
        txq_empty |=> status[2]);

    p_alloc_set_r7: assert property (@(posedge clk) disable iff (rst)
        alloc_evt |=> status[3]);

    p_rx_set_r8: assert property (@(posedge clk) disable iff (rst)
        rx_evt |=> status[0]);

    p_mask_load_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel_mask) |=> (mask == $past(wr_data)));
endmodule

bind irq_stat_ctrl irq_stat_ctrl_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .wr_en           (wr_en),
    .wr_sel_mask     (wr_sel_mask),
    .wr_data         (wr_data),
    .txq_empty       (txq_empty),
    .txdone_nonempty (txdone_nonempty),
    .alloc_evt       (alloc_evt),
    .rx_evt          (rx_evt),
    .rx_pop          (rx_pop),
    .irq             (irq),
    .txdone_pop      (txdone_pop),
    .status          (status),
    .mask            (mask)
);

// File: tb/irq_stat_ctrl_test.sv
module irq_stat_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_sel_mask = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txq_empty = 1'b0, txdone_nonempty = 1'b0, rxq_nonempty = 1'b0;
    logic       alloc_evt = 1'b0, rx_evt = 1'b0, rx_pop = 1'b0;
    logic       irq, txdone_pop;
    logic [7:0] status, mask;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_stat_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel_mask(wr_sel_mask),
        .wr_data(wr_data), .txq_empty(txq_empty),
        .txdone_nonempty(txdone_nonempty), .rxq_nonempty(rxq_nonempty),
        .alloc_evt(alloc_evt), .rx_evt(rx_evt), .rx_pop(rx_pop),
        .irq(irq), .txdone_pop(txdone_pop), .status(status), .mask(mask)
    );

    // {wr, sel_mask, data, {txq_empty, txdone_ne, rxq_ne, alloc, rx, rx_pop},
    //  exp_mask, exp_status, exp_irq, exp_pop}
    localparam int NV = 17;
    localparam logic [33:0] VEC [0:NV-1] = '{
        {1'b1, 1'b1, 8'hFF, 6'b100000, 8'hFF, 8'h04, 1'b1, 1'b0},
        {1'b0, 1'b0, 8'h00, 6'b000100, 8'hFF, 8'h0C, 1'b1, 1'b0},
        {1'b1, 1'b0, 8'hFF, 6'b000000, 8'hFF, 8'h08, 1'b1, 1'b0},
        {1'b1, 1'b1, 8'h04, 6'b000000, 8'h04, 8'h08, 1'b0, 1'b0},
        {1'b0, 1'b0, 8'h00, 6'b001010, 8'h04, 8'h09, 1'b0, 1'b0},
        {1'b0, 1'b0, 8'h00, 6'b001001, 8'h04, 8'h09, 1'b0, 1'b0},
        {1'b0, 1'b0, 8'h00, 6'b000001, 8'h04, 8'h08, 1'b0, 1'b0},
        {1'b0, 1'b0, 8'h00, 6'b000011, 8'h04, 8'h09, 1'b0, 1'b0},
        {1'b0, 1'b0, 8'h00, 6'b010000, 8'h04, 8'h0B, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h02, 6'b010000, 8'h04, 8'h09, 1'b0, 1'b1},
        {1'b0, 1'b0, 8'h00, 6'b010000, 8'h04, 8'h0B, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h02, 6'b000000, 8'h04, 8'h09, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h04, 6'b100000, 8'h04, 8'h0D, 1'b1, 1'b0},
        {1'b1, 1'b1, 8'h00, 6'b000000, 8'h00, 8'h0D, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'h29, 6'b000000, 8'h00, 8'h0D, 1'b0, 1'b0},
        {1'b1, 1'b1, 8'h01, 6'b000000, 8'h01, 8'h0D, 1'b1, 1'b0},
        {1'b1, 1'b0, 8'h04, 6'b000000, 8'h01, 8'h09, 1'b1, 1'b0}
    };
    localparam string TAG [0:NV-1] = '{
        "R9", "R7", "R3", "R2", "R8", "R8", "R8", "R8", "R6",
        "R4", "R6", "R4", "R5", "R2", "R3", "R9", "R5"
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        chk("R1", "status", status, 8'h04);
        chk("R1", "mask", mask, 8'h00);
        chk("R1", "irq", {7'd0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {wr_en, wr_sel_mask, wr_data} = VEC[i][33:24];
            {txq_empty, txdone_nonempty, rxq_nonempty,
             alloc_evt, rx_evt, rx_pop} = VEC[i][23:18];
            #1;
            chk("R4", "txdone_pop", {7'd0, txdone_pop}, {7'd0, VEC[i][0]});
            @(posedge clk);
            #1;
            chk(TAG[i], "status", status, VEC[i][9:2]);
            chk(TAG[i], "mask", mask, VEC[i][17:10]);
            chk("R2", "irq", {7'd0, irq}, {7'd0, VEC[i][1]});
        end

        // R1: reset wins over events and writes in the same cycle
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_sel_mask = 1'b1; wr_data = 8'hAA;
        alloc_evt = 1'b1; rx_evt = 1'b1; txq_empty = 1'b0; txdone_nonempty = 1'b1;
        @(posedge clk); #1;
        chk("R1", "status after reset", status, 8'h04);
        chk("R1", "mask after reset", mask, 8'h00);
        chk("R1", "irq after reset", {7'd0, irq}, 8'h00);
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0; alloc_evt = 1'b0; rx_evt = 1'b0;
        txdone_nonempty = 1'b0;

        // R6: live transmit-done flag sets bit 1 without a pulse
        @(negedge clk) txdone_nonempty = 1'b1;
        @(posedge clk); #1;
        chk("R6", "status bit1 live", status, 8'h06);
        @(negedge clk) txdone_nonempty = 1'b0;
        report();
    end
endmodule